// File: doc/BRIEF.md
# Exception Priority Arbiter and Vectorizer

This block sits beside a processor's sequencer. It collects every pending exception source, picks the one to service and reports its vector number, its vector-table byte address and its priority group. Group 0 (exception-request reset, bus error, address error) is taken in any cycle and tells the sequencer to abort the running instruction. Group 1 (trace, hardware interrupts, illegal instruction, privilege violation) and group 2 (exceptions raised by the executing instruction, such as trap, overflow trap, bounds check and zero divide) are only taken in a cycle where the sequencer reports instruction completion. They never abort.

Hardware interrupts arrive as a 3-bit active-low priority code on asynchronous pins. The code is synchronized and compared with the status-register mask. Level 7 is non-maskable and is recognised only on its arrival edge. An accepted interrupt opens an acknowledge phase, during which the bus side runs the acknowledge cycle. The vector is not reported until a device answers, which gives an autovector, or until a programmable number of cycles passes without an answer, which gives the spurious vector. The stack push and the bus cycle itself belong to other blocks.

Top module: `exc_arbiter`

## Requirements
- R1: The pins `ipl_n` are active low: the level is the bitwise inverse of the pin code. All pins high (level 0) never requests an interrupt, whatever the mask.
- R2: A level from 1 to 6 is accepted only when it is strictly greater than `int_mask`.
- R3: Level 7 is accepted on the cycle it first appears, even with `int_mask` = 7. Holding level 7 does not request again. A recognised level-7 edge stays pending until an acknowledge phase for level 7 closes by answer or by timeout.
- R4: Group 0 is served in any cycle, with or without `inst_done`, and also during an acknowledge phase. Its priority order is exception reset (vector 0), then bus error (vector 2), then address error (vector 3). It reports `exc_abort` = 1 and `exc_group` = 0.
- R5: With `inst_done` low, no group 1 or group 2 source produces an exception. Such exceptions report `exc_abort` = 0.
- R6: Group 1 order, from highest: trace (vector 9), then an accepted interrupt, then illegal instruction (vector 4), then privilege violation (vector 8). Group 1 reports `exc_group` = 1.
- R7: An instruction-raised trap has the lowest priority. It reports the vector given on `trap_vec` with `exc_group` = 2.
- R8: An accepted interrupt raises `iack_cycle` with `iack_level` set to the level. No exception is reported while `iack_cycle` is high. The phase ends only in a cycle in which an exception is reported.
- R9: An answer on `iack_done` during the acknowledge phase reports autovector 24 + level in group 1.
- R10: If no answer arrives within `ACK_TIMEOUT` cycles of the acknowledge phase, the spurious vector 24 is reported. `exc_valid` rises `ACK_TIMEOUT` clock edges after the edge that raised `iack_cycle`.
- R11: `exc_addr` equals `exc_vector` times 4.
- R12: A group 0 source arriving during an acknowledge phase, including in the same cycle as the answer, wins and closes the phase. A pending level-7 edge survives this and is acknowledged again at the next completion.
- R13: After reset, `exc_valid` and `iack_cycle` are low. Each decision is reported as a one-cycle `exc_valid` pulse, one clock edge after the cycle in which its request was presented.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ipl_n | input | 3 | Active-low interrupt priority code (asynchronous) |
| int_mask | input | 3 | Interrupt mask from the status register |
| inst_done | input | 1 | Current instruction completes this cycle |
| reset_req | input | 1 | Exception-request reset (group 0) |
| bus_err | input | 1 | Bus error (group 0) |
| addr_err | input | 1 | Address error (group 0) |
| trace_req | input | 1 | Trace flag set for the completing instruction |
| illegal_req | input | 1 | Illegal instruction detected |
| priv_req | input | 1 | Privilege violation detected |
| trap_req | input | 1 | Instruction-raised exception (group 2) |
| trap_vec | input | 8 | Vector for the instruction-raised exception |
| iack_done | input | 1 | A device answered the interrupt acknowledge |
| iack_cycle | output | 1 | Acknowledge phase in progress |
| iack_level | output | 3 | Level being acknowledged |
| exc_valid | output | 1 | One-cycle pulse: an exception was chosen |
| exc_abort | output | 1 | Chosen exception aborts the current instruction |
| exc_group | output | 2 | Priority group of the chosen exception (0, 1, 2) |
| exc_vector | output | 8 | Vector number |
| exc_addr | output | 10 | Vector-table byte address |

## Verification
Two functions collide in one cycle: the closing of an acknowledge phase (a device answer or the timeout) and the arrival of a group 0 fault. The bench opens a level-7 acknowledge phase and then drives a bus error and the device answer in the same cycle. It expects vector 2 with abort, and a closed phase. It then requires the surviving level-7 edge to open a fresh acknowledge phase at the next completion and to end in autovector 31. A second collision, trace arriving together with an accepted interrupt at completion, must give vector 9 and no acknowledge phase.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  localparam int VEC_W = 8;
  localparam int LVL_W = 3;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    GRP_ABORT    = 2'd0,
    GRP_BOUNDARY = 2'd1,
    GRP_INSTR    = 2'd2,
    GRP_NONE     = 2'd3
  } grp_e;

  typedef enum logic {ST_RUN = 1'b0, ST_ACK = 1'b1} arb_st_e;

  typedef struct packed {
    logic  valid;
    logic  is_int;
    grp_e  grp;
    vec_t  vec;
  } pick_t;

  localparam vec_t VEC_RESET    = 8'd0;
  localparam vec_t VEC_BUSERR   = 8'd2;
  localparam vec_t VEC_ADDRERR  = 8'd3;
  localparam vec_t VEC_ILLEGAL  = 8'd4;
  localparam vec_t VEC_PRIV     = 8'd8;
  localparam vec_t VEC_TRACE    = 8'd9;
  localparam vec_t VEC_SPURIOUS = 8'd24;
  localparam lvl_t LVL_NMI      = 3'd7;

  function automatic lvl_t pins_to_level(input lvl_t pins_n);
    return ~pins_n;
  endfunction

  function automatic logic level_beats_mask(input lvl_t lvl, input lvl_t mask);
    return (lvl != LVL_NMI) && (lvl > mask);
  endfunction

  function automatic vec_t autovec(input lvl_t lvl);
    return VEC_SPURIOUS + vec_t'(lvl);
  endfunction

  function automatic logic [VEC_W+1:0] vec_to_addr(input vec_t v);
    return {v, 2'b00};
  endfunction

  function automatic pick_t make_pick(input grp_e g, input vec_t v, input logic intr);
    pick_t p;
    p.valid  = 1'b1;
    p.is_int = intr;
    p.grp    = g;
    p.vec    = v;
    return p;
  endfunction
endpackage

// File: rtl/exc_ipl_sync.sv
`timescale 1ns/1ps
module exc_ipl_sync import exc_pkg::*; #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  lvl_t ipl_n,
  input  lvl_t mask,
  input  logic nmi_clr,
  output logic take,
  output lvl_t take_level,
  output logic nmi_pend
);
  lvl_t chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '1;
          else        chain[0] <= ipl_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  lvl_t level;
  logic was_nmi;
  logic nmi_edge;

  assign level    = pins_to_level(chain[STAGES-1]);
  assign nmi_edge = (level == LVL_NMI) && !was_nmi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      was_nmi  <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      was_nmi <= (level == LVL_NMI);
      if (nmi_edge)     nmi_pend <= 1'b1;
      else if (nmi_clr) nmi_pend <= 1'b0;
    end

  assign take       = nmi_pend || level_beats_mask(level, mask);
  assign take_level = nmi_pend ? LVL_NMI : level;
endmodule

// File: rtl/exc_prio.sv
`timescale 1ns/1ps
module exc_prio import exc_pkg::*; (
  input  logic  allow_late,
  input  logic  reset_req,
  input  logic  bus_err,
  input  logic  addr_err,
  input  logic  trace_req,
  input  logic  int_take,
  input  lvl_t  int_level,
  input  logic  illegal_req,
  input  logic  priv_req,
  input  logic  trap_req,
  input  vec_t  trap_vec,
  output pick_t pick
);
  always_comb begin
    pick = '{valid: 1'b0, is_int: 1'b0, grp: GRP_NONE, vec: '0};
    if (reset_req)
      pick = make_pick(GRP_ABORT, VEC_RESET, 1'b0);
    else if (bus_err)
      pick = make_pick(GRP_ABORT, VEC_BUSERR, 1'b0);
    else if (addr_err)
      pick = make_pick(GRP_ABORT, VEC_ADDRERR, 1'b0);
    else if (allow_late) begin
      if (trace_req)
        pick = make_pick(GRP_BOUNDARY, VEC_TRACE, 1'b0);
      else if (int_take)
        pick = make_pick(GRP_BOUNDARY, autovec(int_level), 1'b1);
      else if (illegal_req)
        pick = make_pick(GRP_BOUNDARY, VEC_ILLEGAL, 1'b0);
      else if (priv_req)
        pick = make_pick(GRP_BOUNDARY, VEC_PRIV, 1'b0);
      else if (trap_req)
        pick = make_pick(GRP_INSTR, trap_vec, 1'b0);
    end
  end
endmodule

// File: rtl/exc_ack_timer.sv
`timescale 1ns/1ps
module exc_ack_timer #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter import exc_pkg::*; #(
  parameter int ACK_TIMEOUT = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] ipl_n,
  input  logic [LVL_W-1:0] int_mask,
  input  logic             inst_done,
  input  logic             reset_req,
  input  logic             bus_err,
  input  logic             addr_err,
  input  logic             trace_req,
  input  logic             illegal_req,
  input  logic             priv_req,
  input  logic             trap_req,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic             iack_done,
  output logic             iack_cycle,
  output logic [LVL_W-1:0] iack_level,
  output logic             exc_valid,
  output logic             exc_abort,
  output logic [1:0]       exc_group,
  output logic [VEC_W-1:0] exc_vector,
  output logic [VEC_W+1:0] exc_addr
);
  arb_st_e state, state_nx;
  lvl_t    ack_lvl;
  pick_t   pick;
  logic    int_take;
  lvl_t    int_level;
  logic    allow_late;
  logic    emit, open_ack, ack_close;
  vec_t    emit_vec;
  grp_e    emit_grp;

  // named internal events, observed by the checker
  logic ev_nmi_pend;
  logic ev_ack_expired;
  logic ev_nmi_clr;

  assign allow_late = (state == ST_RUN) && inst_done;
  assign ev_nmi_clr = ack_close && (ack_lvl == LVL_NMI);

  exc_ipl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .ipl_n      (ipl_n),
    .mask       (int_mask),
    .nmi_clr    (ev_nmi_clr),
    .take       (int_take),
    .take_level (int_level),
    .nmi_pend   (ev_nmi_pend)
  );

  exc_prio u_prio (
    .allow_late  (allow_late),
    .reset_req   (reset_req),
    .bus_err     (bus_err),
    .addr_err    (addr_err),
    .trace_req   (trace_req),
    .int_take    (int_take),
    .int_level   (int_level),
    .illegal_req (illegal_req),
    .priv_req    (priv_req),
    .trap_req    (trap_req),
    .trap_vec    (trap_vec),
    .pick        (pick)
  );

  exc_ack_timer #(.TIMEOUT(ACK_TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == ST_ACK),
    .expired (ev_ack_expired)
  );

  always_comb begin
    state_nx  = state;
    emit      = 1'b0;
    open_ack  = 1'b0;
    ack_close = 1'b0;
    emit_vec  = pick.vec;
    emit_grp  = pick.grp;
    if (state == ST_RUN) begin
      if (pick.valid) begin
        if (pick.is_int) begin
          open_ack = 1'b1;
          state_nx = ST_ACK;
        end else begin
          emit = 1'b1;
        end
      end
    end else begin
      if (pick.valid) begin
        emit     = 1'b1;
        state_nx = ST_RUN;
      end else if (iack_done) begin
        emit      = 1'b1;
        ack_close = 1'b1;
        emit_vec  = autovec(ack_lvl);
        emit_grp  = GRP_BOUNDARY;
        state_nx  = ST_RUN;
      end else if (ev_ack_expired) begin
        emit      = 1'b1;
        ack_close = 1'b1;
        emit_vec  = VEC_SPURIOUS;
        emit_grp  = GRP_BOUNDARY;
        state_nx  = ST_RUN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= ST_RUN;
      ack_lvl    <= '0;
      exc_valid  <= 1'b0;
      exc_abort  <= 1'b0;
      exc_group  <= GRP_NONE;
      exc_vector <= '0;
      exc_addr   <= '0;
    end else begin
      state     <= state_nx;
      exc_valid <= emit;
      if (open_ack) ack_lvl <= int_level;
      if (emit) begin
        exc_vector <= emit_vec;
        exc_addr   <= vec_to_addr(emit_vec);
        exc_group  <= emit_grp;
        exc_abort  <= (emit_grp == GRP_ABORT);
      end
    end

  assign iack_cycle = (state == ST_ACK);
  assign iack_level = ack_lvl;
endmodule

// File: rtl/exc_arbiter_chk.sv
`timescale 1ns/1ps
module exc_arbiter_chk #(
  parameter int ACK_TIMEOUT = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       inst_done,
  input logic       iack_cycle,
  input logic [2:0] iack_level,
  input logic       exc_valid,
  input logic       exc_abort,
  input logic [7:0] exc_vector,
  input logic       ev_nmi_pend
);
  int streak;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          streak <= 0;
    else if (iack_cycle) streak <= streak + 1;
    else                 streak <= 0;

  AST_ABORT_VECTORS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && exc_abort |-> (exc_vector == 8'd0 || exc_vector == 8'd2 || exc_vector == 8'd3)); // R4
  AST_LATE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && !exc_abort && !$past(iack_cycle) |-> $past(inst_done)); // R5
  AST_NO_REPORT_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !iack_cycle); // R8
  AST_ACK_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    iack_cycle |-> iack_level != 3'd0); // R8
  AST_ACK_CLOSES_WITH_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iack_cycle) |-> exc_valid); // R8
  AST_AUTOVEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && !exc_abort && $past(iack_cycle) |-> (exc_vector >= 8'd24 && exc_vector <= 8'd31)); // R9
  AST_SPURIOUS_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && exc_vector == 8'd24 |-> $past(iack_cycle)); // R10
  AST_ACK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    iack_cycle |-> streak < ACK_TIMEOUT); // R10
  AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ev_nmi_pend) |-> $past(iack_cycle) && $past(iack_level) == 3'd7); // R3
endmodule

bind exc_arbiter exc_arbiter_chk #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .inst_done   (inst_done),
  .iack_cycle  (iack_cycle),
  .iack_level  (iack_level),
  .exc_valid   (exc_valid),
  .exc_abort   (exc_abort),
  .exc_vector  (exc_vector),
  .ev_nmi_pend (ev_nmi_pend)
);

// File: tb/sim_exc_arbiter.sv
`timescale 1ns/1ps
module sim_exc_arbiter;
  localparam int TMO  = 16;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ipl_n = 3'b111;
  logic [2:0] int_mask = 3'd0;
  logic       inst_done = 1'b0;
  logic       reset_req = 1'b0, bus_err = 1'b0, addr_err = 1'b0;
  logic       trace_req = 1'b0, illegal_req = 1'b0, priv_req = 1'b0, trap_req = 1'b0;
  logic [7:0] trap_vec = 8'd0;
  logic       iack_done = 1'b0;
  logic       iack_cycle;
  logic [2:0] iack_level;
  logic       exc_valid, exc_abort;
  logic [1:0] exc_group;
  logic [7:0] exc_vector;
  logic [9:0] exc_addr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  exc_arbiter #(.ACK_TIMEOUT(TMO), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .ipl_n(ipl_n), .int_mask(int_mask), .inst_done(inst_done),
    .reset_req(reset_req), .bus_err(bus_err), .addr_err(addr_err), .trace_req(trace_req),
    .illegal_req(illegal_req), .priv_req(priv_req), .trap_req(trap_req), .trap_vec(trap_vec),
    .iack_done(iack_done), .iack_cycle(iack_cycle), .iack_level(iack_level),
    .exc_valid(exc_valid), .exc_abort(exc_abort), .exc_group(exc_group),
    .exc_vector(exc_vector), .exc_addr(exc_addr));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    inst_done = 0; reset_req = 0; bus_err = 0; addr_err = 0; trace_req = 0;
    illegal_req = 0; priv_req = 0; trap_req = 0; iack_done = 0;
  endtask

  task automatic set_level(input int lvl);
    ipl_n = ~3'(lvl);
    repeat (SYNC + 2) tick();
  endtask

  // expect a reported exception with vector, group, abort and address
  task automatic expect_exc(input string req, input int vec, input int grp, input int abrt);
    chk(req, "exc_valid", int'(exc_valid), 1);
    chk(req, "exc_vector", int'(exc_vector), vec);
    chk(req, "exc_group", int'(exc_group), grp);
    chk(req, "exc_abort", int'(exc_abort), abrt);
    chk("R11", "exc_addr", int'(exc_addr), vec * 4);
  endtask

  task automatic t_reset_state();
    chk("R13", "exc_valid after reset", int'(exc_valid), 0);
    chk("R13", "iack_cycle after reset", int'(iack_cycle), 0);
  endtask

  task automatic t_group0();
    reset_req = 1; bus_err = 1; addr_err = 1; tick(); quiet();
    expect_exc("R4", 0, 0, 1);
    tick();
    chk("R13", "single pulse", int'(exc_valid), 0);
    bus_err = 1; addr_err = 1; tick(); quiet();
    expect_exc("R4", 2, 0, 1);
    addr_err = 1; tick(); quiet();
    expect_exc("R4", 3, 0, 1);
  endtask

  task automatic t_group1_order();
    illegal_req = 1; priv_req = 1; trap_req = 1; trap_vec = 8'd37; tick();
    chk("R5", "no report without inst_done", int'(exc_valid), 0);
    set_level(3);
    inst_done = 1; trace_req = 1; illegal_req = 1; priv_req = 1; trap_req = 1; tick(); quiet();
    expect_exc("R6", 9, 1, 0);
    chk("R6", "trace beats interrupt, no ack", int'(iack_cycle), 0);
    set_level(0);
    inst_done = 1; illegal_req = 1; priv_req = 1; trap_req = 1; tick(); quiet();
    expect_exc("R6", 4, 1, 0);
    inst_done = 1; priv_req = 1; trap_req = 1; tick(); quiet();
    expect_exc("R6", 8, 1, 0);
    inst_done = 1; trap_req = 1; tick(); quiet();
    expect_exc("R7", 37, 2, 0);
  endtask

  task automatic t_mask_and_answer();
    int_mask = 0;
    inst_done = 1; tick(); quiet();
    chk("R1", "level 0 never requests", int'(exc_valid | iack_cycle), 0);
    int_mask = 3; set_level(3);
    inst_done = 1; tick(); quiet();
    chk("R2", "level equal to mask ignored", int'(exc_valid | iack_cycle), 0);
    int_mask = 2;
    inst_done = 1; illegal_req = 1; tick(); quiet();
    chk("R2", "level above mask opens ack", int'(iack_cycle), 1);
    chk("R8", "iack_level", int'(iack_level), 3);
    chk("R8", "no report while acking", int'(exc_valid), 0);
    iack_done = 1; tick(); quiet();
    expect_exc("R9", 27, 1, 0);
    chk("R9", "ack closed", int'(iack_cycle), 0);
    set_level(0);
  endtask

  task automatic t_spurious();
    int_mask = 0; set_level(5);
    inst_done = 1; tick(); quiet();
    chk("R10", "ack open", int'(iack_cycle), 1);
    set_level(0);
    repeat (TMO - 1 - (SYNC + 2)) tick();
    chk("R10", "no report before timeout", int'(exc_valid), 0);
    chk("R10", "still acking", int'(iack_cycle), 1);
    tick();
    expect_exc("R10", 24, 1, 0);
    chk("R10", "ack closed", int'(iack_cycle), 0);
  endtask

  task automatic t_nmi();
    int_mask = 7; set_level(7);
    inst_done = 1; tick(); quiet();
    chk("R3", "level 7 edge taken under mask 7", int'(iack_cycle), 1);
    chk("R3", "iack_level", int'(iack_level), 7);
    iack_done = 1; tick(); quiet();
    expect_exc("R9", 31, 1, 0);
    inst_done = 1; tick(); quiet();
    chk("R3", "held level 7 not retaken", int'(exc_valid | iack_cycle), 0);
    set_level(6);
    inst_done = 1; tick(); quiet();
    chk("R2", "level 6 under mask 7 ignored", int'(exc_valid | iack_cycle), 0);
    set_level(7);
    inst_done = 1; tick(); quiet();
    chk("R3", "new edge taken", int'(iack_cycle), 1);
    iack_done = 1; tick(); quiet();
    expect_exc("R9", 31, 1, 0);
    set_level(0);
  endtask

  task automatic t_collide();
    int_mask = 0; set_level(7);
    inst_done = 1; tick(); quiet();
    chk("R12", "ack open level 7", int'(iack_cycle), 1);
    bus_err = 1; iack_done = 1; tick(); quiet();
    expect_exc("R12", 2, 0, 1);
    chk("R12", "ack abandoned", int'(iack_cycle), 0);
    inst_done = 1; tick(); quiet();
    chk("R12", "pending edge reacknowledged", int'(iack_cycle), 1);
    chk("R12", "level", int'(iack_level), 7);
    reset_req = 1; tick(); quiet();
    expect_exc("R4", 0, 0, 1);
    inst_done = 1; tick(); quiet();
    chk("R12", "edge still pending", int'(iack_cycle), 1);
    iack_done = 1; tick(); quiet();
    expect_exc("R12", 31, 1, 0);
    inst_done = 1; tick(); quiet();
    chk("R3", "edge consumed", int'(exc_valid | iack_cycle), 0);
    set_level(0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset_state();
    t_group0();
    t_group1_order();
    t_mask_and_answer();
    t_spurious();
    t_nmi();
    t_collide();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule